// File: doc/BRIEF.md
# Nine-Bit Address-Detect Receive Filter

This stage sits behind a serial receiver that delivers 9-bit characters, one per single-cycle strobe, and decides which of them reach the receive data path. In pass-all mode every character is forwarded and raises a receive event. In address mode, only characters whose ninth bit (bit 8) is set are forwarded. Characters with that bit clear are discarded with no event. This supports multidrop links, where a station listens only for address characters until one names it.

The mode is one bit of a 32-bit control word, bit 2. Software sets it to wait for an address, inspects each forwarded address character, and clears the bit once its own address appears, so the data that follows passes unfiltered. The filter never changes the mode bit by itself. Each forwarded character appears one cycle after its strobe, with a one-cycle valid pulse and a one-cycle event pulse. The output data register keeps the last forwarded character.

Top module: `addr_filter9`

## Requirements
- R1: After reset, out_valid_o and rx_irq_o are 0, out_data_o is 0 and addr_mode_o is 0 (pass-all).
- R2: With addr_mode_o at 0, every strobed character is presented on out_data_o in the next cycle, with out_valid_o and rx_irq_o both high.
- R3: With addr_mode_o at 1, a strobed character whose bit 8 is 0 is discarded: in the next cycle out_valid_o and rx_irq_o stay low.
- R4: With addr_mode_o at 1, a strobed character whose bit 8 is 1 is forwarded exactly as in R2.
- R5: A write of the 32-bit control word (ctrl_we_i high) loads the mode bit from bit 2 of ctrl_wdata_i, where 1 selects address mode. The new value shows on addr_mode_o in the next cycle, and all other bits of the word have no effect.
- R6: The mode bit changes only through a control write. Forwarding or discarding characters never alters it.
- R7: A control write in the same cycle as a character strobe does not affect that character. The character is filtered under the mode held before the write, and the new mode applies from the next strobe on.
- R8: out_valid_o and rx_irq_o are high only in the cycle after an accepted strobe. With no strobe, or a discarded one, both are low in the next cycle.
- R9: out_data_o changes only when a character is forwarded. Discarded characters and idle cycles leave the last forwarded value in place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| char_valid_i | input | 1 | Single-cycle strobe for an incoming character |
| char_data_i | input | 9 | Incoming character; bit 8 is the address flag |
| ctrl_we_i | input | 1 | Control word write strobe |
| ctrl_wdata_i | input | 32 | Control word; bit 2 is the address-mode bit |
| addr_mode_o | output | 1 | Current mode: 1 selects address mode |
| out_valid_o | output | 1 | Single-cycle pulse for a forwarded character |
| out_data_o | output | 9 | Last forwarded character |
| rx_irq_o | output | 1 | Single-cycle receive event pulse |

## Verification
All 512 character codes are strobed in pass-all mode and again in address mode. This separates the two halves of the code space and shows whether the filter looks at bit 8 and at nothing else. Discarded characters are placed between forwarded ones, and idle gaps are placed between strobes, to show whether the held output data or the pulses leak. Control writes are made with every other bit of the word set and with only bit 2 set, and some of them coincide with a strobe, to separate the decoded bit from its neighbours and the old mode from the new.

// File: rtl/addr_filter9_pkg.sv
package addr_filter9_pkg;
  typedef enum logic {
    MODE_PASS_ALL = 1'b0,
    MODE_ADDR     = 1'b1
  } filt_mode_e;
endpackage

// File: rtl/addr_filter9_mode_reg.sv
module addr_filter9_mode_reg
  import addr_filter9_pkg::*;
#(
  parameter int CTRL_W   = 32,
  parameter int MODE_BIT = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [CTRL_W-1:0] wdata_i,
  output filt_mode_e        mode_o
);
  filt_mode_e mode_q;
  logic unused_ctrl_bits;

  assign unused_ctrl_bits = ^{wdata_i[CTRL_W-1:MODE_BIT+1], wdata_i[MODE_BIT-1:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mode_q <= MODE_PASS_ALL;
    else if (we_i) mode_q <= filt_mode_e'(wdata_i[MODE_BIT]);
  end

  assign mode_o = mode_q;

  // R5
  mode_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (mode_o == filt_mode_e'($past(wdata_i[MODE_BIT]))));
  // R6
  mode_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(mode_o));
endmodule

// File: rtl/addr_filter9_decide.sv
module addr_filter9_decide
  import addr_filter9_pkg::*;
#(
  parameter int DATA_W = 9
) (
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  input  filt_mode_e        mode_i,
  output logic              accept_o
);
  localparam int FlagBit = DATA_W - 1;

  always_comb begin
    unique case (mode_i)
      MODE_ADDR: accept_o = valid_i && data_i[FlagBit];
      default:   accept_o = valid_i;
    endcase
  end
endmodule

// File: rtl/addr_filter9_out.sv
module addr_filter9_out #(
  parameter int DATA_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  output logic              irq_o
);
  logic              valid_q, irq_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      valid_q <= accept_i;
      irq_q   <= accept_i;
    end
  end

  // data register loads only on accept; dropped chars leave it alone
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       data_q <= '0;
    else if (accept_i) data_q <= data_i;
  end

  assign valid_o = valid_q;
  assign irq_o   = irq_q;
  assign data_o  = data_q;

  // R8
  pulse_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !accept_i |=> (!valid_o && !irq_o));
  // R8
  irq_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> irq_o);
  // R9
  data_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !accept_i |=> $stable(data_o));
endmodule

// File: rtl/addr_filter9.sv
module addr_filter9
  import addr_filter9_pkg::*;
#(
  parameter int DATA_W   = 9,
  parameter int CTRL_W   = 32,
  parameter int MODE_BIT = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              char_valid_i,
  input  logic [DATA_W-1:0] char_data_i,
  input  logic              ctrl_we_i,
  input  logic [CTRL_W-1:0] ctrl_wdata_i,
  output logic              addr_mode_o,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] out_data_o,
  output logic              rx_irq_o
);
  localparam int FlagBit = DATA_W - 1;

  filt_mode_e mode;
  logic       accept;

  addr_filter9_mode_reg #(.CTRL_W(CTRL_W), .MODE_BIT(MODE_BIT)) u_mode (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (ctrl_we_i),
    .wdata_i (ctrl_wdata_i),
    .mode_o  (mode)
  );

  // filter sees the registered mode, so a same-cycle write applies to the next strobe
  addr_filter9_decide #(.DATA_W(DATA_W)) u_decide (
    .valid_i  (char_valid_i),
    .data_i   (char_data_i),
    .mode_i   (mode),
    .accept_o (accept)
  );

  addr_filter9_out #(.DATA_W(DATA_W)) u_out (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .accept_i (accept),
    .data_i   (char_data_i),
    .valid_o  (out_valid_o),
    .data_o   (out_data_o),
    .irq_o    (rx_irq_o)
  );

  assign addr_mode_o = (mode == MODE_ADDR);

  // R2
  pass_all_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (char_valid_i && !addr_mode_o) |=>
      (out_valid_o && rx_irq_o && out_data_o == $past(char_data_i)));
  // R3
  drop_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (char_valid_i && addr_mode_o && !char_data_i[FlagBit]) |=>
      (!out_valid_o && !rx_irq_o));
  // R4
  pass_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (char_valid_i && addr_mode_o && char_data_i[FlagBit]) |=>
      (out_valid_o && rx_irq_o && out_data_o == $past(char_data_i)));
endmodule

// File: tb/addr_filter9_tb_top.sv
module addr_filter9_tb_top;
  localparam int ClkPeriod = 10;
  localparam int DataW = 9;
  localparam int CtrlW = 32;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             char_valid_i = 1'b0;
  logic [DataW-1:0] char_data_i = '0;
  logic             ctrl_we_i = 1'b0;
  logic [CtrlW-1:0] ctrl_wdata_i = '0;
  logic             addr_mode_o, out_valid_o, rx_irq_o;
  logic [DataW-1:0] out_data_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  bit mode_m = 1'b0;
  logic [DataW-1:0] last_m = '0;

  always #(ClkPeriod/2) clk_i = ~clk_i;

  addr_filter9 dut_i (
    .clk_i, .rst_ni, .char_valid_i, .char_data_i, .ctrl_we_i, .ctrl_wdata_i,
    .addr_mode_o, .out_valid_o, .out_data_o, .rx_irq_o
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one cycle: optional char strobe and optional control write, then check outputs
  task automatic step(input bit v, input logic [DataW-1:0] ch,
                      input bit we, input logic [CtrlW-1:0] wd, input string req);
    bit pass;
    @(negedge clk_i);
    char_valid_i = v; char_data_i = ch; ctrl_we_i = we; ctrl_wdata_i = wd;
    pass = v && (!mode_m || ch[DataW-1]);
    if (pass) last_m = ch;
    if (we) mode_m = wd[2];
    @(posedge clk_i); #1;
    char_valid_i = 1'b0; ctrl_we_i = 1'b0;
    chk({req, " valid"}, {31'd0, out_valid_o}, {31'd0, pass});
    chk({req, " irq"},   {31'd0, rx_irq_o},    {31'd0, pass});
    chk({req, " data"},  {23'd0, out_data_o},  {23'd0, last_m});
    chk({req, " mode"},  {31'd0, addr_mode_o}, {31'd0, mode_m});
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    // R1 reset state
    chk("R1 valid", {31'd0, out_valid_o}, 0);
    chk("R1 irq",   {31'd0, rx_irq_o}, 0);
    chk("R1 data",  {23'd0, out_data_o}, 0);
    chk("R1 mode",  {31'd0, addr_mode_o}, 0);
    @(negedge clk_i); rst_ni = 1'b1;

    // R2 sweep all codes in pass-all mode, with idle gaps (R8, R9)
    for (int c = 0; c < 512; c++) begin
      step(1'b1, c[DataW-1:0], 1'b0, '0, "R2");
      step(1'b0, 9'h0AA, 1'b0, '0, "R8_idle");
    end

    // R5 write with every bit except 2 set: mode stays off
    step(1'b0, '0, 1'b1, 32'hFFFF_FFFB, "R5_others");
    step(1'b1, 9'h055, 1'b0, '0, "R5_still_pass");
    // R5 set only bit 2
    step(1'b0, '0, 1'b1, 32'h0000_0004, "R5_set");

    // R3 R4 sweep in address mode; R6 mode never self-clears
    for (int c = 0; c < 512; c++) begin
      step(1'b1, c[DataW-1:0], 1'b0, '0, c[8] ? "R4" : "R3");
      step(1'b0, 9'h1FF, 1'b0, '0, "R9_hold");
    end
    step(1'b0, '0, 1'b0, '0, "R6");

    // R7 clear in same cycle as a data char: old mode drops it
    step(1'b1, 9'h012, 1'b1, 32'h0000_0000, "R7_old_mode");
    step(1'b1, 9'h034, 1'b0, '0, "R7_new_mode");
    // R7 set in same cycle: char still passes, next data char dropped
    step(1'b1, 9'h056, 1'b1, 32'hFFFF_FFFF, "R7_set_same");
    step(1'b1, 9'h078, 1'b0, '0, "R7_after_set");
    // R8 back-to-back accepted strobes then dropped
    step(1'b1, 9'h1A5, 1'b0, '0, "R8_b2b");
    step(1'b1, 9'h1C3, 1'b0, '0, "R8_b2b");
    step(1'b1, 9'h0C3, 1'b0, '0, "R9_drop");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule